// File: doc/BRIEF.md
# 8-bit ALU with Carry and Post-Shift

This block is the purely combinational arithmetic and logic stage of a small 8-bit processor core. The core picks the two operands and presents them on `opa_i` and `opb_i`, together with the stored carry flag. The block then runs one of eight operations, followed by an optional one-bit right shift. It returns the byte to be written back, plus the next values of the carry flag and the zero flag. It holds no state, so every output follows its inputs within the same cycle. Choosing the operands and writing the register file stay in the core.

Inside the block are three stages. The operation stage holds the adder and subtractor and the bitwise and move paths. The post-shift stage takes the result of the operation stage. The zero detector looks at the shifted byte. The carry comes from the operation stage alone. Because the block has no state machine, it has no states and no transitions.

Top module: `alu8_top`

## Requirements
- R1: Operation code 000 gives `opa_i + opb_i`. `carry_o` is bit 8 of the 9-bit sum. `carry_i` has no effect.
- R2: Operation code 001 gives `opa_i + opb_i + carry_i`. `carry_o` is bit 8 of the 9-bit sum.
- R3: Operation code 010 gives `opa_i - (opb_i + carry_i)` modulo 256. `carry_o` is 1 exactly when a borrow occurs, that is when `opa_i < opb_i + carry_i`.
- R4: Operation code 011 passes `opa_i` through unchanged. Operation code 111 passes `opb_i` through unchanged.
- R5: Operation codes 100, 101 and 110 give bitwise XOR, OR and AND of the two operands.
- R6: For operation codes 011 to 111, `carry_o` is 0 whatever `carry_i` is.
- R7: Shift code 01 shifts the operation result right by one bit and fills bit 7 with 0.
- R8: Shift code 10 shifts the operation result right by one bit and keeps bit 7 equal to the operation result's bit 7.
- R9: Shift codes 00 and 11 both leave the operation result unchanged.
- R10: `zero_o` is 1 exactly when the final 8-bit `result_o`, taken after any shift, is 0x00.
- R11: `carry_o` depends only on the operation stage and is the same for every shift code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 8 | First operand (register, memory byte or immediate) |
| opb_i | input | 8 | Second operand |
| op_i | input | 3 | Operation code |
| shift_i | input | 2 | Post-operation shift code |
| carry_i | input | 1 | Stored carry flag |
| result_o | output | 8 | Final result after the shift |
| carry_o | output | 1 | Next carry flag |
| zero_o | output | 1 | Next zero flag |

## Verification
Two of the block's functions can act in the same cycle: a carry or borrow out of the arithmetic stage, and a shift that drops the bit that was just produced. The bench provokes this with vectors such as 0x80 + 0x81 under a logical shift, where the single set bit is shifted away. In that case the result must read zero, and the carry must still come from the unshifted sum. An arithmetic shift of a borrowed 0xFF is also checked, to confirm that sign fill and borrow both appear. A random sweep then compares every operation and shift pair, with both carry-in values, against an arithmetic model written in the bench.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_ADC   = 3'b001,
        OP_SUBC  = 3'b010,
        OP_PASSA = 3'b011,
        OP_XOR   = 3'b100,
        OP_OR    = 3'b101,
        OP_AND   = 3'b110,
        OP_PASSB = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'b00,
        SH_LSR  = 2'b01,
        SH_ASR  = 2'b10,
        SH_RSVD = 2'b11
    } shift_e;
endpackage

// File: rtl/alu8_opstage.sv
module alu8_opstage
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   op_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic         use_cin;
    logic [W:0]   sum;
    logic [W:0]   diff;
    alu_op_e      op;

    assign op      = alu_op_e'(op_i);
    assign use_cin = (op == OP_ADC) & cin_i;
    assign sum     = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, use_cin};
    assign diff    = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};

    always_comb begin
        res_o  = '0;
        cout_o = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res_o  = sum[W-1:0];
                cout_o = sum[W];
            end
            OP_SUBC: begin
                res_o  = diff[W-1:0];
                cout_o = diff[W];
            end
            OP_PASSA: res_o = a_i;
            OP_XOR:   res_o = a_i ^ b_i;
            OP_OR:    res_o = a_i | b_i;
            OP_AND:   res_o = a_i & b_i;
            OP_PASSB: res_o = b_i;
        endcase
    end

    always_comb begin
        if (op_i[2] | (op_i == 3'b011)) begin
            AST_LOGIC_NO_CARRY: assert (cout_o == 1'b0); // R6
        end
    end
endmodule

// File: rtl/alu8_postshift.sv
module alu8_postshift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] d_i,
    input  logic [1:0]   shift_i,
    output logic [W-1:0] q_o
);
    always_comb begin
        unique case (shift_e'(shift_i))
            SH_LSR:           q_o = {1'b0, d_i[W-1:1]};
            SH_ASR:           q_o = {d_i[W-1], d_i[W-1:1]};
            SH_NONE, SH_RSVD: q_o = d_i;
        endcase
    end

    always_comb begin
        if (shift_i == 2'b01) begin
            AST_LSR_MSB_CLEAR: assert (q_o[W-1] == 1'b0); // R7
        end
        if (shift_i == 2'b10) begin
            AST_ASR_SIGN_KEPT: assert (q_o[W-1] == d_i[W-1]); // R8
        end
    end
endmodule

// File: rtl/alu8_zerodet.sv
module alu8_zerodet #(
    parameter int W = 8
) (
    input  logic [W-1:0] v_i,
    output logic         zero_o
);
    assign zero_o = ~(|v_i);
endmodule

// File: rtl/alu8_top.sv
module alu8_top
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [2:0]   op_i,
    input  logic [1:0]   shift_i,
    input  logic         carry_i,
    output logic [W-1:0] result_o,
    output logic         carry_o,
    output logic         zero_o
);
    logic [W-1:0] op_res;

    alu8_opstage #(.W(W)) u_op (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .op_i   (op_i),
        .cin_i  (carry_i),
        .res_o  (op_res),
        .cout_o (carry_o)
    );

    alu8_postshift #(.W(W)) u_sh (
        .d_i     (op_res),
        .shift_i (shift_i),
        .q_o     (result_o)
    );

    alu8_zerodet #(.W(W)) u_zd (
        .v_i    (result_o),
        .zero_o (zero_o)
    );

    always_comb begin
        if (shift_i == 2'b00 || shift_i == 2'b11) begin
            if (op_i == 3'b011) begin
                AST_PASSA_THROUGH: assert (result_o == opa_i); // R4
            end
            if (op_i == 3'b111) begin
                AST_PASSB_THROUGH: assert (result_o == opb_i); // R4
            end
        end
        if (zero_o) begin
            AST_ZERO_IMPLIES_LOW_BITS: assert (result_o[0] == 1'b0); // R10
        end
    end
endmodule

// File: tb/alu8_top_bench.sv
`timescale 1ns/1ps
module alu8_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opa, opb;
    logic [2:0] op;
    logic [1:0] sh;
    logic       cin;
    logic [7:0] res;
    logic       cout, zf;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alu8_top u_alu8_top (
        .opa_i(opa), .opb_i(opb), .op_i(op), .shift_i(sh), .carry_i(cin),
        .result_o(res), .carry_o(cout), .zero_o(zf)
    );

    // entry: op[31:29] sh[28:27] cin[26] a[25:18] b[17:10] res[9:2] c[1] z[0]
    localparam int NV = 18;
    localparam logic [31:0] VEC [NV] = '{
        {3'd0, 2'd0, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b0}, // R1
        {3'd0, 2'd0, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1}, // R1 R10
        {3'd0, 2'd0, 1'b1, 8'hFF, 8'hFF, 8'hFE, 1'b1, 1'b0}, // R1 carry_i ignored
        {3'd1, 2'd0, 1'b1, 8'h10, 8'h20, 8'h31, 1'b0, 1'b0}, // R2
        {3'd1, 2'd0, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1}, // R2
        {3'd2, 2'd0, 1'b1, 8'h50, 8'h20, 8'h2F, 1'b0, 1'b0}, // R3
        {3'd2, 2'd0, 1'b1, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0}, // R3 borrow
        {3'd2, 2'd0, 1'b0, 8'h20, 8'h20, 8'h00, 1'b0, 1'b1}, // R3
        {3'd3, 2'd0, 1'b1, 8'h5A, 8'h33, 8'h5A, 1'b0, 1'b0}, // R4 R6
        {3'd7, 2'd0, 1'b1, 8'h5A, 8'hC3, 8'hC3, 1'b0, 1'b0}, // R4 R6
        {3'd4, 2'd0, 1'b1, 8'hF0, 8'hFF, 8'h0F, 1'b0, 1'b0}, // R5 R6
        {3'd5, 2'd0, 1'b0, 8'h0C, 8'h30, 8'h3C, 1'b0, 1'b0}, // R5
        {3'd6, 2'd0, 1'b1, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b1}, // R5 R10
        {3'd0, 2'd1, 1'b0, 8'h80, 8'h81, 8'h00, 1'b1, 1'b1}, // R7 R10 R11
        {3'd3, 2'd2, 1'b0, 8'h81, 8'h00, 8'hC0, 1'b0, 1'b0}, // R8
        {3'd3, 2'd1, 1'b0, 8'h81, 8'h00, 8'h40, 1'b0, 1'b0}, // R7
        {3'd3, 2'd3, 1'b0, 8'h81, 8'h00, 8'h81, 1'b0, 1'b0}, // R9
        {3'd2, 2'd2, 1'b0, 8'h01, 8'h02, 8'hFF, 1'b1, 1'b0}  // R8 R3 R11
    };

    task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic c,
                         input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op = o; sh = s; cin = c; opa = a; opb = b;
        #2;
    endtask

    task automatic check(input string tag, input logic [7:0] er,
                         input logic ec, input logic ez);
        checks++;
        if (res !== er || cout !== ec || zf !== ez) begin
            errors++;
            $display("FAIL %s op=%0d sh=%0d cin=%0d a=%h b=%h: got res=%h c=%b z=%b, expected res=%h c=%b z=%b",
                     tag, op, sh, cin, opa, opb, res, cout, zf, er, ec, ez);
        end
    endtask

    function automatic logic [9:0] model(input logic [2:0] o, input logic [1:0] s,
                                         input logic c, input logic [7:0] a,
                                         input logic [7:0] b);
        int t;
        logic [7:0] r;
        logic k;
        k = 1'b0;
        case (o)
            3'd0: begin t = int'(a) + int'(b); r = t[7:0]; k = (t > 255); end
            3'd1: begin t = int'(a) + int'(b) + int'(c); r = t[7:0]; k = (t > 255); end
            3'd2: begin t = int'(a) - int'(b) - int'(c); r = t[7:0]; k = (t < 0); end
            3'd3: r = a;
            3'd4: r = a ^ b;
            3'd5: r = a | b;
            3'd6: r = a & b;
            default: r = b;
        endcase
        if (s == 2'd1) r = r / 2;
        else if (s == 2'd2) r = (r / 2) | (r & 8'h80);
        return {r, k, (r == 8'h00)};
    endfunction

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        op = '0; sh = '0; cin = 1'b0; opa = '0; opb = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // quiet inputs after reset: R1 R10
        apply(3'd0, 2'd0, 1'b0, 8'h00, 8'h00);
        check("R1 R10 idle", 8'h00, 1'b0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][31:29], VEC[i][28:27], VEC[i][26], VEC[i][25:18], VEC[i][17:10]);
            check($sformatf("vector %0d", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R11: carry identical across all shift codes
        for (int s = 0; s < 4; s++) begin
            logic [9:0] m;
            m = model(3'd1, 2'(s), 1'b1, 8'hC3, 8'h7D);
            apply(3'd1, 2'(s), 1'b1, 8'hC3, 8'h7D);
            check("R11 shift sweep", m[9:2], 1'b1, m[0]);
        end

        // R9 reserved code equals none on a borrow case
        apply(3'd2, 2'd3, 1'b1, 8'h10, 8'h10);
        check("R9 R3 rsvd shift", 8'hFF, 1'b1, 1'b0);

        // random sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < 600; i++) begin
            logic [2:0] o;
            logic [1:0] s;
            logic c;
            logic [7:0] a, b;
            logic [9:0] m;
            o = 3'(i % 8);
            s = 2'((i / 8) % 4);
            c = 1'((i / 32) % 2);
            a = 8'($urandom);
            b = 8'($urandom);
            m = model(o, s, c, a, b);
            apply(o, s, c, a, b);
            check("random R1-model", m[9:2], m[1], m[0]);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule